// File: doc/BRIEF.md
# BIP-8 Error Accumulator With Snapshot

This block watches a stream of per-frame parity bytes. On every cycle in which the frame strobe is high, it compares the locally computed 8-bit interleaved parity byte with the byte taken from the line. It keeps two running totals. The first counts the individual bits that disagree; these are the parity errors. The second counts the frames that had at least one disagreeing bit; these are the block errors. Both totals saturate instead of wrapping. Computing the parity byte itself happens upstream and is not part of this block.

A one-cycle tick, normally once per second, copies both running totals into snapshot registers that the host reads. A control bit decides what happens to the running totals at that copy: they either restart from zero or carry on. While any line defect is present, counting stops. Out-of-frame only stops counting when the host enables it.

A counted mismatch sets a sticky status bit. The host clears that bit by writing a one to it. The status bit, gated by a mask bit, drives the interrupt line. The host sees the block through a small register port: one write port and one combinational read port.

Top module: `bip8_err_accum`

## Requirements
- R1: For each counted frame, the parity-error total rises by the number of bit positions in which the calculated and received bytes differ. For example, 0x5A against 0x1D adds 4.
- R2: For each counted frame, the block-error total rises by exactly 1 when the two bytes differ, and by 0 when they are equal.
- R3: The parity-error total is PAR_W bits wide (default 24) and the block-error total is BLK_W bits wide (default 20). Each total holds at its all-ones value instead of wrapping.
- R4: In the cycle `sec_tick` is high, both totals are copied into snapshot registers. The host reads the parity snapshot at read address 2 and the block snapshot at read address 3, zero-extended.
- R5: Control register (address 0) bit 0 selects the action at a copy. When it is 1, the totals restart from zero. When it is 0, they keep their value.
- R6: A frame that arrives in the same cycle as a copy is left out of that snapshot and is counted into the following interval, whether the totals restart or carry on.
- R7: While any of `dfx_lof`, `dfx_los`, `dfx_ais`, `dfx_oci` or `dfx_lck` is high, frames are neither counted nor able to set the status bit.
- R8: `dfx_oof` stops counting only while control bit 1 is 1. When that bit is 0, frames during out-of-frame are counted as usual.
- R9: Status register (address 1) bit 0 is set by every counted mismatch. The host clears it by writing a 1 to that bit. If a mismatch arrives in the same cycle as the clearing write, the bit stays set.
- R10: `irq` is high exactly when status bit 0 and control bit 2 (the mask enable) are both 1.
- R11: After reset, the control register, status bit, both snapshots, both totals and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: parity bytes valid |
| bip_calc | input | 8 | Locally computed parity byte |
| bip_rcvd | input | 8 | Parity byte received from the line |
| dfx_oof | input | 1 | Out-of-frame defect |
| dfx_lof | input | 1 | Loss-of-frame defect |
| dfx_los | input | 1 | Loss-of-signal defect |
| dfx_ais | input | 1 | Alarm indication signal defect |
| dfx_oci | input | 1 | Open connection indication defect |
| dfx_lck | input | 1 | Locked defect |
| sec_tick | input | 1 | One-cycle snapshot tick |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | HOST_W | Host write data |
| rd_addr | input | 2 | Host read address |
| rd_data | output | HOST_W | Host read data (combinational) |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions rest on a few assumptions about the inputs. Each frame strobe and each tick is a level taken at a single clock edge. Every increment fits in one adder step, because the increment width is narrower than either total. A total can therefore move only by the increment of that cycle, or restart at a copy. The stimulus changes every input on the falling edge and holds the defect flags as levels across whole frames. Ticks are issued both alone and coincident with frames, so each snapshot can be predicted from the model of the previous interval. A second instance with narrow totals reaches the saturation ceiling within a few dozen frames, which keeps the wrap-free property in reach of the stimulus.

// File: rtl/bip8_pkg.sv
package bip8_pkg;

    localparam int BIP_W  = 8;
    localparam int NBIT_W = $clog2(BIP_W + 1);

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_STAT  = 2'd1,
        REG_PSNAP = 2'd2,
        REG_BSNAP = 2'd3
    } reg_addr_e;

    // bit 2: interrupt enable, bit 1: OOF gating enable, bit 0: clear on copy
    typedef struct packed {
        logic irq_en;
        logic oof_gate;
        logic clr_on_copy;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic oof;
        logic lof;
        logic los;
        logic ais;
        logic oci;
        logic lck;
    } defect_t;

    typedef struct packed {
        logic              hit;
        logic [NBIT_W-1:0] nbits;
    } cmp_res_t;

    function automatic logic [NBIT_W-1:0] count_ones(input logic [BIP_W-1:0] v);
        logic [NBIT_W-1:0] n;
        n = '0;
        for (int i = 0; i < BIP_W; i++) begin
            n = n + NBIT_W'(v[i]);
        end
        return n;
    endfunction

    function automatic logic pause_active(input defect_t d, input logic oof_gate);
        return d.lof | d.los | d.ais | d.oci | d.lck | (d.oof & oof_gate);
    endfunction

endpackage

// File: rtl/bip8_compare.sv
module bip8_compare
    import bip8_pkg::*;
(
    input  logic             valid,
    input  logic             hold,
    input  logic [BIP_W-1:0] calc,
    input  logic [BIP_W-1:0] rcvd,
    output cmp_res_t         res
);

    logic [NBIT_W-1:0] ones;

    always_comb begin
        ones = count_ones(calc ^ rcvd);
        if (!valid || hold) begin
            ones = '0;
        end
        res.nbits = ones;
        res.hit   = (ones != '0);
    end

endmodule

// File: rtl/bip8_sat_accum.sv
module bip8_sat_accum #(
    parameter int W     = 24,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    input  logic             copy,
    input  logic             clr_on_copy,
    output logic [W-1:0]     snap
);

    localparam int           SUM_W   = W + 1;
    localparam logic [W-1:0] ACC_MAX = {W{1'b1}};

    logic [W-1:0]     acc;
    logic [W-1:0]     base;
    logic [SUM_W-1:0] sum;
    logic [W-1:0]     acc_nxt;

    always_comb begin
        base    = (copy && clr_on_copy) ? '0 : acc;
        sum     = {1'b0, base} + SUM_W'(inc);
        acc_nxt = sum[W] ? ACC_MAX : sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            snap <= '0;
        end else begin
            acc <= acc_nxt;
            if (copy) begin
                snap <= acc;
            end
        end
    end

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        !(copy && clr_on_copy) |=> acc >= $past(acc));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (inc == '0 && !copy) |=> $stable(acc));

    assert_snap_copy_R4: assert property (@(posedge clk) disable iff (rst)
        copy |=> snap == $past(acc));

    assert_restart_keeps_frame_R6: assert property (@(posedge clk) disable iff (rst)
        (copy && clr_on_copy) |=> acc == W'($past(inc)));

endmodule

// File: rtl/bip8_host_regs.sv
module bip8_host_regs
    import bip8_pkg::*;
#(
    parameter int HOST_W = 32,
    parameter int PAR_W  = 24,
    parameter int BLK_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HOST_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [HOST_W-1:0] rd_data,
    input  logic              err_hit,
    input  logic [PAR_W-1:0]  par_snap,
    input  logic [BLK_W-1:0]  blk_snap,
    output ctrl_t             ctrl,
    output logic              irq
);

    logic sticky;
    logic w1c_req;
    logic ctrl_wr;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data[HOST_W-1:CTRL_W];
    assign ctrl_wr = wr_en && (reg_addr_e'(wr_addr) == REG_CTRL);
    assign w1c_req = wr_en && (reg_addr_e'(wr_addr) == REG_STAT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            sticky <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            end
            sticky <= (sticky && !w1c_req) || err_hit;
        end
    end

    assign irq = sticky && ctrl.irq_en;

    always_comb begin
        case (reg_addr_e'(rd_addr))
            REG_CTRL:  rd_data = HOST_W'(ctrl);
            REG_STAT:  rd_data = HOST_W'(sticky);
            REG_PSNAP: rd_data = HOST_W'(par_snap);
            default:   rd_data = HOST_W'(blk_snap);
        endcase
    end

    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
        err_hit |=> sticky);

    assert_sticky_only_by_host_R9: assert property (@(posedge clk) disable iff (rst)
        (sticky && !w1c_req) |=> sticky);

endmodule

// File: rtl/bip8_err_accum.sv
module bip8_err_accum
    import bip8_pkg::*;
#(
    parameter int HOST_W = 32,
    parameter int PAR_W  = 24,
    parameter int BLK_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_valid,
    input  logic [7:0]        bip_calc,
    input  logic [7:0]        bip_rcvd,
    input  logic              dfx_oof,
    input  logic              dfx_lof,
    input  logic              dfx_los,
    input  logic              dfx_ais,
    input  logic              dfx_oci,
    input  logic              dfx_lck,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HOST_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [HOST_W-1:0] rd_data,
    output logic              irq
);

    defect_t          dfx;
    ctrl_t            ctrl;
    logic             paused;
    cmp_res_t         cmp;
    logic [PAR_W-1:0] par_snap;
    logic [BLK_W-1:0] blk_snap;

    assign dfx    = '{oof: dfx_oof, lof: dfx_lof, los: dfx_los,
                      ais: dfx_ais, oci: dfx_oci, lck: dfx_lck};
    assign paused = pause_active(dfx, ctrl.oof_gate);

    bip8_compare u_cmp (
        .valid (frm_valid),
        .hold  (paused),
        .calc  (bip_calc),
        .rcvd  (bip_rcvd),
        .res   (cmp)
    );

    bip8_sat_accum #(.W(PAR_W), .INC_W(NBIT_W)) u_par_acc (
        .clk         (clk),
        .rst         (rst),
        .inc         (cmp.nbits),
        .copy        (sec_tick),
        .clr_on_copy (ctrl.clr_on_copy),
        .snap        (par_snap)
    );

    bip8_sat_accum #(.W(BLK_W), .INC_W(1)) u_blk_acc (
        .clk         (clk),
        .rst         (rst),
        .inc         (cmp.hit),
        .copy        (sec_tick),
        .clr_on_copy (ctrl.clr_on_copy),
        .snap        (blk_snap)
    );

    bip8_host_regs #(.HOST_W(HOST_W), .PAR_W(PAR_W), .BLK_W(BLK_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .err_hit  (cmp.hit),
        .par_snap (par_snap),
        .blk_snap (blk_snap),
        .ctrl     (ctrl),
        .irq      (irq)
    );

    assert_defect_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (dfx_lof || dfx_los || dfx_ais || dfx_oci || dfx_lck) |-> (cmp.nbits == '0 && !cmp.hit));

    assert_oof_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (dfx_oof && ctrl.oof_gate) |-> !cmp.hit);

endmodule

// File: tb/test_bip8_err_accum.sv
module test_bip8_err_accum;
    import bip8_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HW = 32;
    localparam int NP = 6;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frm_valid = 1'b0;
    logic [7:0] bip_calc = '0, bip_rcvd = '0;
    logic dfx_oof = 0, dfx_lof = 0, dfx_los = 0, dfx_ais = 0, dfx_oci = 0, dfx_lck = 0;
    logic sec_tick = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [HW-1:0] wr_data = '0;
    logic [HW-1:0] rd_data, rd_data_n;
    logic irq, irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    bip8_err_accum i_bip8_err_accum (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .bip_calc(bip_calc), .bip_rcvd(bip_rcvd),
        .dfx_oof(dfx_oof), .dfx_lof(dfx_lof), .dfx_los(dfx_los), .dfx_ais(dfx_ais),
        .dfx_oci(dfx_oci), .dfx_lck(dfx_lck), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

    bip8_err_accum #(.HOST_W(HW), .PAR_W(NP), .BLK_W(NB)) i_bip8_err_accum_narrow (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .bip_calc(bip_calc), .bip_rcvd(bip_rcvd),
        .dfx_oof(dfx_oof), .dfx_lof(dfx_lof), .dfx_los(dfx_los), .dfx_ais(dfx_ais),
        .dfx_oci(dfx_oci), .dfx_lck(dfx_lck), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_n), .irq(irq_n));

    typedef struct {
        int    par;
        int    blk;
        int    npar;
        int    nblk;
        string tag;
    } snap_t;

    snap_t q[$];
    int nchk = 0, nerr = 0;
    bit done = 0;

    // reference model
    int m_par = 0, m_blk = 0, n_par = 0, n_blk = 0;
    bit m_sts = 0, c_clr = 0, c_oof = 0, c_irq = 0;

    function automatic int satadd(int a, int b, int w);
        int cap = (1 << w) - 1;
        return (a + b > cap) ? cap : a + b;
    endfunction

    function automatic int ones8(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock of stimulus; called at a falling edge, returns at the next one
    task automatic step(bit v, logic [7:0] c, logic [7:0] r, bit tk,
                        bit we, logic [1:0] wa, logic [HW-1:0] wd, string tag);
        snap_t e;
        bit paused, err;
        int d;
        frm_valid = v; bip_calc = c; bip_rcvd = r; sec_tick = tk;
        wr_en = we; wr_addr = wa; wr_data = wd;
        e = '{par: m_par, blk: m_blk, npar: n_par, nblk: n_blk, tag: tag};
        if (tk && c_clr) begin
            m_par = 0; m_blk = 0; n_par = 0; n_blk = 0;
        end
        paused = dfx_lof | dfx_los | dfx_ais | dfx_oci | dfx_lck | (dfx_oof & c_oof);
        d = (v && !paused) ? ones8(c ^ r) : 0;
        err = (d > 0);
        m_par = satadd(m_par, d, 24);  m_blk = satadd(m_blk, int'(err), 20);
        n_par = satadd(n_par, d, NP);  n_blk = satadd(n_blk, int'(err), NB);
        m_sts = (m_sts && !(we && wa == 2'd1 && wd[0])) || err;
        @(posedge clk);
        if (we && wa == 2'd0) begin
            c_clr = wd[0]; c_oof = wd[1]; c_irq = wd[2];
        end
        if (tk) q.push_back(e);
        @(negedge clk);
        frm_valid = 0; sec_tick = 0; wr_en = 0;
    endtask

    task automatic frame(logic [7:0] c, logic [7:0] r);
        step(1, c, r, 0, 0, 2'd0, '0, "");
    endtask

    task automatic tick(string tag);
        step(0, 8'h00, 8'h00, 1, 0, 2'd0, '0, tag);
    endtask

    task automatic hwrite(logic [1:0] a, logic [HW-1:0] d);
        step(0, 8'h00, 8'h00, 0, 1, a, d, "");
    endtask

    task automatic check_status(string req);
        wait (q.size() == 0);
        rd_addr = 2'd1; #1;
        chk({req, " status"}, int'(rd_data[0]), int'(m_sts));
        chk({req, " status narrow"}, int'(rd_data_n[0]), int'(m_sts));
        chk({req, " irq"}, int'(irq), int'(m_sts && c_irq));
    endtask

    // monitor: compares each snapshot after the tick edge that produced it
    always @(negedge clk) begin
        snap_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            rd_addr = 2'd2; #1;
            chk({e.tag, " R1 parity snapshot"}, int'(rd_data), e.par);
            chk({e.tag, " R3 narrow parity snapshot"}, int'(rd_data_n), e.npar);
            rd_addr = 2'd3; #1;
            chk({e.tag, " R2 block snapshot"}, int'(rd_data), e.blk);
            chk({e.tag, " R3 narrow block snapshot"}, int'(rd_data_n), e.nblk);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            chk("R11 reset register", int'(rd_data), 0);
        end
        chk("R11 reset irq", int'(irq), 0);

        // R1 R2 R4: counting in retain mode
        frame(8'h5A, 8'h1D);
        frame(8'hFF, 8'hFF);
        frame(8'h00, 8'hFF);
        frame(8'h80, 8'h00);
        tick("R4 first interval");
        // R5 retain
        frame(8'h03, 8'h00);
        tick("R5 retain");
        // R5 clear
        hwrite(2'd0, 32'h1);
        wait (q.size() == 0);
        rd_addr = 2'd0; #1;
        chk("R5 control readback", int'(rd_data), 1);
        tick("R5 copy before clear");
        tick("R5 after clear");
        // R6 frame coincident with tick in clear mode
        frame(8'hF0, 8'h00);
        step(1, 8'h0F, 8'h00, 1, 0, 2'd0, '0, "R6 coincident clear");
        tick("R6 next interval");
        // R6 in retain mode
        hwrite(2'd0, 32'h0);
        step(1, 8'h01, 8'h00, 1, 0, 2'd0, '0, "R6 coincident retain");
        tick("R6 retain next");

        // R7 defects block counting and status
        hwrite(2'd0, 32'h1);
        tick("R7 flush");
        hwrite(2'd1, 32'h1);
        check_status("R9 cleared before R7");
        dfx_lof = 1; frame(8'hFF, 8'h00); dfx_lof = 0;
        dfx_los = 1; frame(8'hFF, 8'h00); dfx_los = 0;
        dfx_ais = 1; frame(8'hFF, 8'h00); dfx_ais = 0;
        dfx_oci = 1; frame(8'hFF, 8'h00); dfx_oci = 0;
        dfx_lck = 1; frame(8'hFF, 8'h00); dfx_lck = 0;
        check_status("R7 no status under defect");
        tick("R7 defects paused");

        // R8 OOF gating
        dfx_oof = 1; frame(8'h01, 8'h00); dfx_oof = 0;
        hwrite(2'd0, 32'h3);
        dfx_oof = 1; frame(8'hFF, 8'h00); dfx_oof = 0;
        tick("R8 oof gate");

        // R9 R10 status and interrupt
        hwrite(2'd0, 32'h1);
        hwrite(2'd1, 32'h1);
        check_status("R9 w1c");
        frame(8'h10, 8'h00);
        check_status("R9 set by error");
        hwrite(2'd0, 32'h5);
        check_status("R10 mask enable");
        step(1, 8'h01, 8'h00, 0, 1, 2'd1, 32'h1, "");
        check_status("R9 error wins over clear");
        hwrite(2'd1, 32'h1);
        check_status("R10 irq drops after clear");
        tick("R9 flush");

        // R3 saturation (narrow instance), fresh start in retain mode
        @(negedge clk); rst = 1;
        @(posedge clk); @(negedge clk); rst = 0;
        m_par = 0; m_blk = 0; n_par = 0; n_blk = 0; m_sts = 0;
        c_clr = 0; c_oof = 0; c_irq = 0;
        for (int i = 0; i < 20; i++) frame(8'hFF, 8'h00);
        tick("R3 saturate");
        frame(8'hFF, 8'h00);
        tick("R3 hold at max");

        wait (q.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule